// File: doc/BRIEF.md
# SDRAM Read-Port FIFO Filler

This block sits between the read side of a single-data-rate SDRAM controller and a local 32-bit receive FIFO that it owns. A one-cycle start pulse hands it a 26-bit word address and a transfer length. The block presents that address to the controller with a single-cycle enable. It then asks for words by holding ready, and burst as well, for as long as the FIFO has room and words remain to be requested. Words that come back are written straight into the FIFO on the port's valid strobe, and local logic drains them through a show-ahead pop interface.

The controller's done strobe only says that a word has been requested. The data follows a fixed pipeline later on a separate valid strobe. For that reason the almost-full point keeps a safety margin of free entries, and an in-flight counter tracks requests that have not yet returned. The idle output therefore only rises once a transfer has fully drained, not merely once requesting has stopped.

Top module: `sdram_rd_filler`

## Requirements
- R1: One cycle after start is sampled high, portAddrEn is high for exactly one cycle with portAddr equal to startAddr. portReady is low in that cycle and may rise in the following cycle.
- R2: portReady is high exactly when an address has been issued, at least one requested word of the length remains, and the FIFO does not hold DEPTH entries.
- R3: portBurst is high exactly when portReady is high and more than AF_FREE entries are free (free = DEPTH minus entries held). Because of this, requesting stops before the FIFO can overflow, even with words still in flight.
- R4: AF_FREE must be at least 6, which covers five returning words plus one final request. A smaller value, or one not below DEPTH, stops elaboration.
- R5: On every cycle with portDval high, portData is written into the FIFO. No word is lost, and words leave in arrival order. popData shows the oldest entry while fifoEmpty is low, popEn removes it, and popEn while empty has no effect.
- R6: Each portDone pulse uses up one word of the loaded length. After as many done pulses as the length, portReady stays low, so no extra word is requested. A length of zero requests nothing.
- R7: idle is high exactly when no requested word is still awaiting its valid strobe and portReady is low.
- R8: A transfer resumes after the controller closes a row mid-transfer, as long as ready and burst stay high, until the full length is delivered in address order.
- R9: After reset, portAddrEn, portReady and portBurst are low, fifoEmpty is high and idle is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM controller's read port |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that loads startAddr and xferLen |
| startAddr | input | 26 | First word address of the transfer |
| xferLen | input | 16 | Number of words to request |
| portAddrEn | output | 1 | Single-cycle address enable to the controller |
| portAddr | output | 26 | Address presented with portAddrEn |
| portReady | output | 1 | Space available, words wanted |
| portBurst | output | 1 | Several words may be streamed |
| portDone | input | 1 | One word has been requested from memory |
| portDval | input | 1 | A returned word is on portData |
| portData | input | 32 | Returned read data |
| popEn | input | 1 | Remove the oldest FIFO entry |
| popData | output | 32 | Oldest FIFO entry |
| fifoEmpty | output | 1 | FIFO holds no entries |
| idle | output | 1 | Nothing requested, nothing in flight |

## Verification
The bench builds the block with a 16-entry FIFO and the smallest legal margin of 6. This puts the almost-full point at 10 entries, so a transfer left undrained runs into the stop condition, with a full return pipeline still to land, within a few dozen cycles. The port model closes rows every 8 addresses and returns data 5 cycles after each request. A 40-word transfer started just below the top of the 26-bit space therefore crosses several row reopens and the address wrap. Zero- and one-word lengths and a pop on an empty FIFO cover the edges of the length and FIFO logic.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic reqIssued;
    logic pushWord;
    logic popWord;
  } fillStrobes_t;

  // Status from datapath to control
  typedef struct packed {
    logic full;
    logic almostFull;
    logic empty;
    logic drained;
  } fillStatus_t;

endpackage

// File: rtl/rd_fill_dp.sv
module rd_fill_dp
  import sdram_rd_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter int AF_FREE = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobes_t      strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] portData,
  output logic [ADDR_W-1:0] portAddr,
  output logic [DATA_W-1:0] popData,
  output fillStatus_t       status
);

  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int AF_LEVEL = DEPTH - AF_FREE;

  // R4: margin must cover the return pipeline plus one last request
  generate
    if (AF_FREE < 6 || AF_FREE >= DEPTH) begin : g_badMargin
      initial $fatal(1, "AF_FREE must be at least 6 and below DEPTH");
    end
  endgenerate

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  outstanding;
  logic [ADDR_W-1:0] addrQ;
  logic              pushOk;

  assign pushOk = strobes.pushWord && ((count != CNT_W'(DEPTH)) || strobes.popWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobes.loadAddr) begin
      addrQ <= startAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) begin
      mem[wrPtr] <= portData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) begin
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (strobes.popWord) begin
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      case ({pushOk, strobes.popWord})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // In-flight requests: up on done, down on returned word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
    end else begin
      case ({strobes.reqIssued, strobes.pushWord})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
    end
  end

  assign portAddr          = addrQ;
  assign popData           = mem[rdPtr];
  assign status.full       = (count == CNT_W'(DEPTH));
  assign status.almostFull = (count >= CNT_W'(AF_LEVEL));
  assign status.empty      = (count == '0);
  assign status.drained    = (outstanding == '0);

  // R5: a returning word always finds room
  a_r5_push_room: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushWord && !strobes.popWord |-> count != CNT_W'(DEPTH));

  // R5: a lone push grows the FIFO by one entry
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushWord && !strobes.popWord |=> count == CNT_W'($past(count) + 1'b1));

  // R7: every returned word was requested earlier
  a_r7_valid_has_request: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushWord |-> outstanding != '0);

endmodule

// File: rtl/rd_fill_ctrl.sv
module rd_fill_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] xferLen,
  input  logic             portDone,
  input  logic             portDval,
  input  logic             popEn,
  input  fillStatus_t      status,
  output fillStrobes_t     strobes,
  output logic             portAddrEn,
  output logic             portReady,
  output logic             portBurst,
  output logic             idle
);

  logic             addrEnQ;
  logic             armed;
  logic [LEN_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrEnQ   <= 1'b0;
      armed     <= 1'b0;
      remaining <= '0;
    end else begin
      addrEnQ <= start;
      if (start) begin
        remaining <= xferLen;
        armed     <= 1'b0;
      end else begin
        if (addrEnQ) begin
          armed <= 1'b1;
        end
        if (portDone && (remaining != '0)) begin
          remaining <= remaining - 1'b1;
        end
      end
    end
  end

  assign portAddrEn = addrEnQ;
  assign portReady  = armed && (remaining != '0) && !status.full;
  assign portBurst  = portReady && !status.almostFull;
  assign idle       = status.drained && !portReady;

  assign strobes.loadAddr  = start;
  assign strobes.reqIssued = portDone;
  assign strobes.pushWord  = portDval;
  assign strobes.popWord   = popEn && !status.empty;

  // R1: address enable lasts a single cycle
  a_r1_addr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    portAddrEn |=> !portAddrEn);

  // R1: address is presented before ready is raised
  a_r1_addr_before_ready: assert property (@(posedge clk) disable iff (!rstN)
    portAddrEn |-> !portReady);

  // R6: no request beyond the loaded length
  a_r6_done_within_len: assert property (@(posedge clk) disable iff (!rstN)
    portDone |-> remaining != '0);

endmodule

// File: rtl/sdram_rd_filler.sv
module sdram_rd_filler
  import sdram_rd_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 16,
  parameter int AF_FREE = 6,
  parameter int LEN_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  xferLen,
  output logic              portAddrEn,
  output logic [ADDR_W-1:0] portAddr,
  output logic              portReady,
  output logic              portBurst,
  input  logic              portDone,
  input  logic              portDval,
  input  logic [DATA_W-1:0] portData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic              fifoEmpty,
  output logic              idle
);

  fillStrobes_t strobes;
  fillStatus_t  status;

  rd_fill_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .xferLen    (xferLen),
    .portDone   (portDone),
    .portDval   (portDval),
    .popEn      (popEn),
    .status     (status),
    .strobes    (strobes),
    .portAddrEn (portAddrEn),
    .portReady  (portReady),
    .portBurst  (portBurst),
    .idle       (idle)
  );

  rd_fill_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DEPTH   (DEPTH),
    .AF_FREE (AF_FREE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .startAddr (startAddr),
    .portData  (portData),
    .portAddr  (portAddr),
    .popData   (popData),
    .status    (status)
  );

  assign fifoEmpty = status.empty;

endmodule

// File: tb/sdram_rd_filler_tb.sv
module sdram_rd_filler_tb;

  localparam int DEPTH    = 16;
  localparam int AF_FREE  = 6;
  localparam int OPEN_DLY = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [25:0] startAddr = '0;
  logic [15:0] xferLen = '0;
  logic        portAddrEn, portReady, portBurst;
  logic [25:0] portAddr;
  logic        portDone, portDval;
  logic [31:0] portData;
  logic        popEn = 1'b0;
  logic [31:0] popData;
  logic        fifoEmpty, idle;

  always #5 clk = ~clk;

  sdram_rd_filler #(.DEPTH(DEPTH), .AF_FREE(AF_FREE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .xferLen(xferLen),
    .portAddrEn(portAddrEn), .portAddr(portAddr), .portReady(portReady), .portBurst(portBurst),
    .portDone(portDone), .portDval(portDval), .portData(portData),
    .popEn(popEn), .popData(popData), .fifoEmpty(fifoEmpty), .idle(idle)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [31:0] wordAt(logic [25:0] a);
    return {6'h15, a};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Port model: 4-cycle row open, row end every 8 addresses, 5-cycle return
  logic        opened;
  int          openCnt;
  logic [25:0] mAddr;
  logic [4:0]  vPipe;
  logic [31:0] dPipe [5];

  assign portDone = opened && portReady;
  assign portDval = vPipe[4];
  assign portData = dPipe[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opened  <= 1'b0;
      openCnt <= 0;
      vPipe   <= '0;
      mAddr   <= '0;
    end else begin
      vPipe    <= {vPipe[3:0], portDone};
      dPipe[0] <= wordAt(mAddr);
      for (int i = 1; i < 5; i++) dPipe[i] <= dPipe[i-1];
      if (portAddrEn) mAddr <= portAddr;
      else if (portDone) mAddr <= mAddr + 1'b1;
      if (opened) begin
        if (!portReady || (portDone && (!portBurst || mAddr[2:0] == 3'd7))) opened <= 1'b0;
      end else if (portReady && portBurst) begin
        if (openCnt == OPEN_DLY - 1) begin
          opened  <= 1'b1;
          openCnt <= 0;
        end else openCnt <= openCnt + 1;
      end else openCnt <= 0;
    end
  end

  // Per-cycle monitor with independent level and in-flight tracking
  bit monOn = 1'b0;
  int lvl = 0;
  int outst = 0;
  int doneCnt = 0;

  always @(negedge clk) begin
    if (monOn) begin
      if (portBurst) chk((DEPTH - lvl) > AF_FREE, "R3", "burst with too little room", lvl, DEPTH - AF_FREE - 1);
      if (portReady && (DEPTH - lvl) > AF_FREE) chk(portBurst, "R3", "burst with room", portBurst, 1);
      if (portReady) chk(lvl < DEPTH, "R2", "ready while full", lvl, DEPTH - 1);
      if (portDval) chk(lvl < DEPTH || popEn, "R5", "word arrives at full FIFO", lvl, DEPTH - 1);
      chk(idle == (outst == 0 && !portReady), "R7", "idle", idle, (outst == 0 && !portReady));
      lvl     = lvl + (portDval ? 1 : 0) - ((popEn && lvl > 0) ? 1 : 0);
      outst   = outst + (portDone ? 1 : 0) - (portDval ? 1 : 0);
      doneCnt = doneCnt + (portDone ? 1 : 0);
    end
  end

  task automatic loadStart(logic [25:0] a, logic [15:0] n);
    @(posedge clk); #2;
    start = 1'b1; startAddr = a; xferLen = n;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    chk(portAddrEn == 1'b1, "R1", "address enable", portAddrEn, 1);
    chk(portAddr == a, "R1", "address value", portAddr, a);
    chk(portReady == 1'b0, "R1", "ready with address", portReady, 0);
    @(negedge clk);
    chk(portAddrEn == 1'b0, "R1", "address enable width", portAddrEn, 0);
    chk(portReady == (n != 0), "R2", "ready after address", portReady, (n != 0));
  endtask

  task automatic waitIdle(string req);
    int w = 0;
    @(negedge clk);
    while (!idle && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(idle, req, "transfer drains", idle, 1);
  endtask

  task automatic popRun(int n, logic [25:0] base, int gap, string req);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      @(posedge clk); #2;
      popEn = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #2;
      end
      while (fifoEmpty && w < 500) begin
        @(posedge clk); #2;
        w++;
      end
      chk(!fifoEmpty, req, "word available", fifoEmpty, 0);
      chk(popData == wordAt(base + 26'(i)), req, "popped word", popData, wordAt(base + 26'(i)));
      popEn = 1'b1;
    end
    @(posedge clk); #2;
    popEn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!portAddrEn, "R9", "reset addrEn", portAddrEn, 0);
    chk(!portReady, "R9", "reset ready", portReady, 0);
    chk(!portBurst, "R9", "reset burst", portBurst, 0);
    chk(fifoEmpty, "R9", "reset empty", fifoEmpty, 1);
    chk(idle, "R9", "reset idle", idle, 1);
  endtask

  task automatic testShort();
    doneCnt = 0;
    loadStart(26'h0012345, 16'd4);
    waitIdle("R7");
    chk(doneCnt == 4, "R6", "requests for length 4", doneCnt, 4);
    chk(!portReady, "R6", "ready after length", portReady, 0);
    popRun(4, 26'h0012345, 0, "R5");
    @(negedge clk);
    chk(fifoEmpty, "R5", "empty after draining", fifoEmpty, 1);
  endtask

  task automatic testSingle();
    doneCnt = 0;
    loadStart(26'h0000007, 16'd1);
    waitIdle("R7");
    chk(doneCnt == 1, "R6", "requests for length 1", doneCnt, 1);
    popRun(1, 26'h0000007, 0, "R5");
  endtask

  task automatic testZero();
    doneCnt = 0;
    loadStart(26'h0000100, 16'd0);
    repeat (20) @(negedge clk);
    chk(doneCnt == 0, "R6", "requests for length 0", doneCnt, 0);
    chk(idle, "R6", "idle for length 0", idle, 1);
  endtask

  task automatic testLongWrap();
    doneCnt = 0;
    loadStart(26'h3FFFFF3, 16'd40);
    popRun(40, 26'h3FFFFF3, 0, "R8");
    waitIdle("R8");
    chk(doneCnt == 40, "R8", "requests across rows", doneCnt, 40);
  endtask

  task automatic testStall();
    doneCnt = 0;
    loadStart(26'h0000200, 16'd30);
    repeat (80) @(negedge clk);
    chk(doneCnt < 30, "R3", "transfer stalls with no drain", doneCnt, 29);
    chk(!portBurst, "R3", "burst low while stalled", portBurst, 0);
    chk(lvl >= DEPTH - AF_FREE, "R3", "level reached margin", lvl, DEPTH - AF_FREE);
    chk(lvl <= DEPTH, "R5", "no overfill", lvl, DEPTH);
    popRun(30, 26'h0000200, 2, "R5");
    waitIdle("R7");
    chk(doneCnt == 30, "R6", "requests after resume", doneCnt, 30);
  endtask

  task automatic testEmptyPop();
    @(posedge clk); #2;
    popEn = 1'b1;
    @(posedge clk); #2;
    popEn = 1'b0;
    @(negedge clk);
    chk(fifoEmpty, "R5", "pop on empty", fifoEmpty, 1);
    loadStart(26'h0000300, 16'd2);
    popRun(2, 26'h0000300, 0, "R5");
    waitIdle("R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    monOn = 1'b1;
    testReset();
    testShort();
    testSingle();
    testZero();
    testLongWrap();
    testStall();
    testEmptyPop();
    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule